// File: doc/BRIEF.md
# Multithreaded Fetch PC Sequencer

This block holds the fetch program counter of each hardware thread in an in-order pipeline. For every thread it keeps a PC, a PC-valid flag, a per-thread sequence counter and the index of the stage that was last blocked on that thread. Pipeline stages send it one request per cycle. An assign request takes the thread's current PC and a fresh sequence number, or stalls if the PC is unknown. An update request reports a control instruction. The block then either freezes fetch for an unpredicted return or asks for a squash on a predicted-taken branch.

Squash events arrive on several parallel ports. When more than one port names the same thread, the oldest squash (lowest sequence number) is the one applied. A non-faulting squash redirects the thread. If the thread was frozen, it also pulses an unblock to the stage that was blocked. Trap, activate and deactivate events reload or retire a thread. Branch prediction, the instruction cache and the trap handler are outside the block; their results arrive as flags and addresses.

Top module: `fetch_pc_sequencer`

## Requirements
- R1: After synchronous reset every thread is inactive. An assign request stalls (`rsp_done` low), and `blk_vld`, `sqr_vld` and `ub_vld` are all low.
- R2: An assign request (`req_cmd`=0) to a thread with a valid PC completes with `rsp_done` high. It returns the thread's PC on `rsp_pc` and its sequence number on `rsp_seq`. After the clock edge the thread's PC is 4 higher and its sequence number is 1 higher.
- R3: An assign request to a thread whose PC is not valid leaves `rsp_done` low and changes neither the thread's PC nor its sequence number.
- R4: A request with `req_fault` high completes with `rsp_done` high, raises neither `blk_vld` nor `sqr_vld`, and leaves the thread's state unchanged.
- R5: An update request (`req_cmd`=1) for a control instruction that is a return and is not predicted taken drives `blk_vld` with the requesting stage and thread. It clears that thread's PC-valid flag, so later assign requests stall, and it records the stage.
- R6: An update request for a predicted-taken control instruction drives `sqr_vld` with the requesting stage and thread. An update request for a non-control instruction completes with no block and no squash request.
- R7: When several squash ports name the same thread in one cycle, only the one with the lowest sequence number is applied. On a tie, the lower port index wins.
- R8: A squash whose instruction has a fault clears the thread's PC-valid flag. A later trap event restores fetch at the supplied PC.
- R9: A squash by a control instruction sets the PC to its target. If the delay-slot PC is flagged valid and equals that target, the PC becomes the target plus 4.
- R10: A squash by a non-control instruction sets the PC to that instruction's PC plus 4.
- R11: A non-faulting squash applied to a thread whose PC-valid flag is clear pulses `ub_vld` for that thread, with `ub_stage` equal to the recorded block stage, in the same cycle. It then sets PC-valid.
- R12: A trap (`ev_kind`=0) or an activate (`ev_kind`=1) loads the thread PC from `ev_pc` and sets PC-valid. A deactivate (`ev_kind`=2) clears PC-valid and resets the recorded block stage to 0. `ev_kind`=3 does nothing.
- R13: On a single thread in one cycle, an event overrides a squash and a squash overrides a request. An assign request to a thread hit by a squash or an event that cycle stalls. A squash overridden by an event gives no unblock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_cmd | input | 1 | 0 = assign next PC, 1 = update target |
| req_tid | input | TID_W | Requesting thread |
| req_stage | input | STG_W | Requesting stage index |
| req_fault | input | 1 | Instruction already carries a fault |
| req_ctrl | input | 1 | Instruction is a control transfer |
| req_ret | input | 1 | Instruction is a return |
| req_ptaken | input | 1 | Instruction predicted taken |
| sq_vld | input | NSQ | Squash valid, per port |
| sq_tid | input | NSQ x TID_W | Squash thread, per port |
| sq_seq | input | NSQ x SEQ_W | Squash sequence number, per port |
| sq_fault | input | NSQ | Squashing instruction faulted |
| sq_ctrl | input | NSQ | Squashing instruction is a control transfer |
| sq_pc | input | NSQ x PC_W | PC of squashing instruction |
| sq_targ | input | NSQ x PC_W | Predicted target of squashing instruction |
| sq_ds_vld | input | NSQ | Following (delay-slot) instruction known |
| sq_ds_pc | input | NSQ x PC_W | PC of following instruction |
| ev_vld | input | 1 | Thread event present |
| ev_kind | input | 2 | 0 trap, 1 activate, 2 deactivate, 3 none |
| ev_tid | input | TID_W | Event thread |
| ev_pc | input | PC_W | Architectural PC for trap or activate |
| rsp_done | output | 1 | Request completed (low = stall) |
| rsp_pc | output | PC_W | PC of the requesting thread |
| rsp_seq | output | SEQ_W | Sequence number of the requesting thread |
| blk_vld | output | 1 | Block the requesting stage |
| blk_stage | output | STG_W | Stage to block |
| blk_tid | output | TID_W | Thread blocked |
| sqr_vld | output | 1 | Squash request |
| sqr_stage | output | STG_W | Stage the squash starts from |
| sqr_tid | output | TID_W | Thread to squash |
| ub_vld | output | NT | Unblock pulse, per thread |
| ub_stage | output | NT x STG_W | Stage to unblock, per thread |

## Verification
The collisions that matter are a squash and an assign request on the same thread in one cycle, and two squash ports naming one thread in one cycle. Directed cycles provoke both. An assign collides with a squash, an event collides with a squash, and two ports carry older, younger and equal sequence numbers. A long stretch of random traffic on few threads with small sequence numbers then makes such collisions frequent. Each cycle, a behavioural model in the bench applies event over squash over request and picks the oldest squash. Its predicted response, block, squash-request and unblock outputs are compared with the design.

// File: rtl/fps_pkg.sv
package fps_pkg;
   typedef enum logic [1:0] {
      EV_TRAP  = 2'd0,
      EV_ACT   = 2'd1,
      EV_DEACT = 2'd2,
      EV_NONE  = 2'd3
   } ev_e;

   typedef enum logic {
      CMD_ASSIGN = 1'b0,
      CMD_UPDATE = 1'b1
   } cmd_e;

   localparam int unsigned INST_BYTES = 4;
endpackage

// File: rtl/fps_sq_arb.sv
module fps_sq_arb #(
   parameter int NT    = 4,
   parameter int NSQ   = 2,
   parameter int TID_W = 2,
   parameter int SEQ_W = 16,
   parameter int IDX_W = 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NSQ-1:0]             vld,
   input  logic [NSQ-1:0][TID_W-1:0]  tid,
   input  logic [NSQ-1:0][SEQ_W-1:0]  seq,
   output logic [NT-1:0]              win,
   output logic [NT-1:0][IDX_W-1:0]   win_idx
);
   logic [NT-1:0][SEQ_W-1:0] best;

   always_comb begin
      for (int t = 0; t < NT; t++) begin
         win[t]     = 1'b0;
         win_idx[t] = '0;
         best[t]    = '0;
         for (int p = 0; p < NSQ; p++) begin
            if (vld[p] && tid[p] == TID_W'(t) && (!win[t] || seq[p] < best[t])) begin
               win[t]     = 1'b1;
               win_idx[t] = IDX_W'(p);
               best[t]    = seq[p];
            end
         end
      end
   end

   for (genvar t = 0; t < NT; t++) begin : g_chk_t
      for (genvar p = 0; p < NSQ; p++) begin : g_chk_p
         // R7
         oldest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (vld[p] && tid[p] == TID_W'(t)) |-> (win[t] && seq[win_idx[t]] <= seq[p]));
      end
   end
endmodule

// File: rtl/fps_redirect.sv
module fps_redirect #(
   parameter int PC_W = 32
) (
   input  logic            ctrl,
   input  logic [PC_W-1:0] pc,
   input  logic [PC_W-1:0] targ,
   input  logic            ds_vld,
   input  logic [PC_W-1:0] ds_pc,
   output logic [PC_W-1:0] npc
);
   import fps_pkg::*;
   localparam logic [PC_W-1:0] STEP = PC_W'(INST_BYTES);

   always_comb begin
      if (!ctrl)
         npc = pc + STEP;
      else if (ds_vld && ds_pc == targ)
         npc = targ + STEP;
      else
         npc = targ;
   end
endmodule

// File: rtl/fps_thread_state.sv
module fps_thread_state #(
   parameter int PC_W  = 32,
   parameter int SEQ_W = 16,
   parameter int STG_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ev_kill,
   input  logic             ev_ld,
   input  logic [PC_W-1:0]  ev_pc,
   input  logic             sq_apply,
   input  logic             sq_fault,
   input  logic [PC_W-1:0]  sq_npc,
   input  logic             blk_set,
   input  logic [STG_W-1:0] blk_stg,
   input  logic             adv,
   output logic [PC_W-1:0]  pc,
   output logic             pcv,
   output logic [SEQ_W-1:0] seq,
   output logic [STG_W-1:0] bstg
);
   import fps_pkg::*;
   localparam logic [PC_W-1:0] STEP = PC_W'(INST_BYTES);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc   <= '0;
         pcv  <= 1'b0;
         seq  <= '0;
         bstg <= '0;
      end else if (ev_kill) begin
         pcv  <= 1'b0;
         bstg <= '0;
      end else if (ev_ld) begin
         pc   <= ev_pc;
         pcv  <= 1'b1;
      end else if (sq_apply) begin
         if (sq_fault) begin
            pcv <= 1'b0;
         end else begin
            pc  <= sq_npc;
            pcv <= 1'b1;
         end
      end else begin
         if (blk_set) begin
            pcv  <= 1'b0;
            bstg <= blk_stg;
         end
         if (adv) begin
            pc  <= pc + STEP;
            seq <= seq + 1'b1;
         end
      end
   end

   // R12
   load_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_ld && !ev_kill) |=> (pcv && pc == $past(ev_pc)));
   // R12
   kill_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_kill |=> (!pcv && bstg == '0));
   // R2
   adv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !ev_kill && !ev_ld && !sq_apply) |=>
         (pc == $past(pc) + STEP && seq == $past(seq) + 1'b1));
   // R5
   block_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_set && !ev_kill && !ev_ld && !sq_apply) |=> (!pcv && bstg == $past(blk_stg)));
endmodule

// File: rtl/fetch_pc_sequencer.sv
module fetch_pc_sequencer #(
   parameter int NT      = 4,
   parameter int NSQ     = 2,
   parameter int NSTAGES = 5,
   parameter int PC_W    = 32,
   parameter int SEQ_W   = 16,
   parameter int TID_W   = $clog2(NT),
   parameter int STG_W   = $clog2(NSTAGES)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_valid,
   input  logic                       req_cmd,
   input  logic [TID_W-1:0]           req_tid,
   input  logic [STG_W-1:0]           req_stage,
   input  logic                       req_fault,
   input  logic                       req_ctrl,
   input  logic                       req_ret,
   input  logic                       req_ptaken,
   input  logic [NSQ-1:0]             sq_vld,
   input  logic [NSQ-1:0][TID_W-1:0]  sq_tid,
   input  logic [NSQ-1:0][SEQ_W-1:0]  sq_seq,
   input  logic [NSQ-1:0]             sq_fault,
   input  logic [NSQ-1:0]             sq_ctrl,
   input  logic [NSQ-1:0][PC_W-1:0]   sq_pc,
   input  logic [NSQ-1:0][PC_W-1:0]   sq_targ,
   input  logic [NSQ-1:0]             sq_ds_vld,
   input  logic [NSQ-1:0][PC_W-1:0]   sq_ds_pc,
   input  logic                       ev_vld,
   input  logic [1:0]                 ev_kind,
   input  logic [TID_W-1:0]           ev_tid,
   input  logic [PC_W-1:0]            ev_pc,
   output logic                       rsp_done,
   output logic [PC_W-1:0]            rsp_pc,
   output logic [SEQ_W-1:0]           rsp_seq,
   output logic                       blk_vld,
   output logic [STG_W-1:0]           blk_stage,
   output logic [TID_W-1:0]           blk_tid,
   output logic                       sqr_vld,
   output logic [STG_W-1:0]           sqr_stage,
   output logic [TID_W-1:0]           sqr_tid,
   output logic [NT-1:0]              ub_vld,
   output logic [NT-1:0][STG_W-1:0]   ub_stage
);
   import fps_pkg::*;
   localparam int IDX_W = (NSQ > 1) ? $clog2(NSQ) : 1;

   if (NT < 2 || (1 << TID_W) != NT) begin : g_bad_nt
      $error("NT must be a power of two of at least 2");
   end
   if (NSQ < 1) begin : g_bad_nsq
      $error("NSQ must be at least 1");
   end
   if (NSTAGES < 2 || (1 << STG_W) < NSTAGES) begin : g_bad_stg
      $error("STG_W too narrow for NSTAGES");
   end

   ev_e  ev_k;
   cmd_e cmd;
   assign ev_k = ev_e'(ev_kind);
   assign cmd  = cmd_e'(req_cmd);

   logic [NT-1:0]             sq_win, ev_hit, pcv_a;
   logic [NT-1:0][IDX_W-1:0]  sq_idx;
   logic [NT-1:0][PC_W-1:0]   pc_a;
   logic [NT-1:0][SEQ_W-1:0]  seq_a;
   logic [NT-1:0][STG_W-1:0]  bstg_a;
   logic [NSQ-1:0][PC_W-1:0]  npc_p;

   fps_sq_arb #(.NT(NT), .NSQ(NSQ), .TID_W(TID_W), .SEQ_W(SEQ_W), .IDX_W(IDX_W)) i_arb (
      .clk(clk), .rst_n(rst_n), .vld(sq_vld), .tid(sq_tid), .seq(sq_seq),
      .win(sq_win), .win_idx(sq_idx));

   for (genvar p = 0; p < NSQ; p++) begin : g_port
      fps_redirect #(.PC_W(PC_W)) i_redir (
         .ctrl(sq_ctrl[p]), .pc(sq_pc[p]), .targ(sq_targ[p]),
         .ds_vld(sq_ds_vld[p]), .ds_pc(sq_ds_pc[p]), .npc(npc_p[p]));
   end

   logic live_req, upd_block, upd_squash;
   assign live_req   = req_valid && !req_fault;
   assign upd_block  = live_req && cmd == CMD_UPDATE && req_ctrl && req_ret && !req_ptaken;
   assign upd_squash = live_req && cmd == CMD_UPDATE && req_ctrl && !upd_block && req_ptaken;

   for (genvar t = 0; t < NT; t++) begin : g_thr
      logic mine, adv;
      assign mine      = live_req && req_tid == TID_W'(t);
      assign ev_hit[t] = ev_vld && ev_tid == TID_W'(t) && ev_k != EV_NONE;
      assign adv       = mine && cmd == CMD_ASSIGN && pcv_a[t] && !sq_win[t] && !ev_hit[t];

      fps_thread_state #(.PC_W(PC_W), .SEQ_W(SEQ_W), .STG_W(STG_W)) i_state (
         .clk(clk), .rst_n(rst_n),
         .ev_kill(ev_hit[t] && ev_k == EV_DEACT),
         .ev_ld(ev_hit[t] && (ev_k == EV_TRAP || ev_k == EV_ACT)),
         .ev_pc(ev_pc),
         .sq_apply(sq_win[t]),
         .sq_fault(sq_fault[sq_idx[t]]),
         .sq_npc(npc_p[sq_idx[t]]),
         .blk_set(upd_block && req_tid == TID_W'(t)),
         .blk_stg(req_stage),
         .adv(adv),
         .pc(pc_a[t]), .pcv(pcv_a[t]), .seq(seq_a[t]), .bstg(bstg_a[t]));

      assign ub_vld[t]   = sq_win[t] && !sq_fault[sq_idx[t]] && !pcv_a[t] && !ev_hit[t];
      assign ub_stage[t] = bstg_a[t];
   end

   assign rsp_pc    = pc_a[req_tid];
   assign rsp_seq   = seq_a[req_tid];
   assign rsp_done  = req_valid && (req_fault || cmd == CMD_UPDATE ||
                      (pcv_a[req_tid] && !sq_win[req_tid] && !ev_hit[req_tid]));
   assign blk_vld   = upd_block;
   assign blk_stage = req_stage;
   assign blk_tid   = req_tid;
   assign sqr_vld   = upd_squash;
   assign sqr_stage = req_stage;
   assign sqr_tid   = req_tid;

   // R4
   fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_fault) |-> (rsp_done && !blk_vld && !sqr_vld));
   // R6
   blk_sqr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(blk_vld && sqr_vld));
endmodule

// File: tb/test_fetch_pc_sequencer.sv
module test_fetch_pc_sequencer;
   localparam int NT = 4, NSQ = 2, NSTG = 5, PC_W = 32, SEQ_W = 16, TID_W = 2, STG_W = 3;

   logic clk = 1'b0, rst_n = 1'b0;
   always #5 clk = ~clk;

   logic req_valid, req_cmd, req_fault, req_ctrl, req_ret, req_ptaken;
   logic [TID_W-1:0] req_tid;
   logic [STG_W-1:0] req_stage;
   logic [NSQ-1:0] sq_vld, sq_fault, sq_ctrl, sq_ds_vld;
   logic [NSQ-1:0][TID_W-1:0] sq_tid;
   logic [NSQ-1:0][SEQ_W-1:0] sq_seq;
   logic [NSQ-1:0][PC_W-1:0] sq_pc, sq_targ, sq_ds_pc;
   logic ev_vld;
   logic [1:0] ev_kind;
   logic [TID_W-1:0] ev_tid;
   logic [PC_W-1:0] ev_pc;
   logic rsp_done, blk_vld, sqr_vld;
   logic [PC_W-1:0] rsp_pc;
   logic [SEQ_W-1:0] rsp_seq;
   logic [STG_W-1:0] blk_stage, sqr_stage;
   logic [TID_W-1:0] blk_tid, sqr_tid;
   logic [NT-1:0] ub_vld;
   logic [NT-1:0][STG_W-1:0] ub_stage;

   fetch_pc_sequencer #(.NT(NT), .NSQ(NSQ), .NSTAGES(NSTG), .PC_W(PC_W), .SEQ_W(SEQ_W))
   i_fetch_pc_sequencer (.*);

   int tests = 0, fails = 0;
   string tag = "R1";

   // reference model state
   logic [PC_W-1:0] m_pc [NT];
   logic [SEQ_W-1:0] m_seq [NT];
   logic m_v [NT];
   int m_bs [NT];
   // per-cycle predictions
   bit e_win [NT];
   int e_idx [NT];
   bit e_ev [NT];

   task automatic chk(input string r, input longint act, input longint exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s (%s): actual %0h expected %0h at %0t", r, tag, act, exp, $time);
      end
   endtask

   function automatic logic [PC_W-1:0] redir(input int p);
      if (!sq_ctrl[p]) return sq_pc[p] + 4;
      if (sq_ds_vld[p] && sq_ds_pc[p] == sq_targ[p]) return sq_targ[p] + 4;
      return sq_targ[p];
   endfunction

   task automatic predict();
      for (int t = 0; t < NT; t++) begin
         e_win[t] = 0; e_idx[t] = 0;
         e_ev[t] = ev_vld && ev_tid == t && ev_kind != 2'd3;
         for (int p = 0; p < NSQ; p++)
            if (sq_vld[p] && sq_tid[p] == t && (!e_win[t] || sq_seq[p] < sq_seq[e_idx[t]])) begin
               e_win[t] = 1; e_idx[t] = p;
            end
      end
   endtask

   task automatic compare();
      bit ok, eb, es;
      int rt;
      predict();
      rt = req_tid;
      ok = req_valid && (req_fault || req_cmd || (m_v[rt] && !e_win[rt] && !e_ev[rt]));
      eb = req_valid && !req_fault && req_cmd && req_ctrl && req_ret && !req_ptaken;
      es = req_valid && !req_fault && req_cmd && req_ctrl && !eb && req_ptaken;
      chk("R2/R3/R13 done", rsp_done, ok);
      if (req_valid) begin
         chk("R2 pc", rsp_pc, m_pc[rt]);
         chk("R2 seq", rsp_seq, m_seq[rt]);
      end
      chk("R5 blk", blk_vld, eb);
      if (eb) begin chk("R5 stage", blk_stage, req_stage); chk("R5 tid", blk_tid, req_tid); end
      chk("R6 sqr", sqr_vld, es);
      if (es) begin chk("R6 stage", sqr_stage, req_stage); chk("R6 tid", sqr_tid, req_tid); end
      for (int t = 0; t < NT; t++) begin
         bit u;
         u = e_win[t] && !sq_fault[e_idx[t]] && !m_v[t] && !e_ev[t];
         chk("R11 ub", ub_vld[t], u);
         if (u) chk("R11 ub_stage", ub_stage[t], m_bs[t]);
      end
   endtask

   task automatic model_step();
      for (int t = 0; t < NT; t++) begin
         if (!rst_n) begin
            m_pc[t] = 0; m_seq[t] = 0; m_v[t] = 0; m_bs[t] = 0;
         end else if (e_ev[t]) begin
            if (ev_kind == 2'd2) begin m_v[t] = 0; m_bs[t] = 0; end
            else begin m_pc[t] = ev_pc; m_v[t] = 1; end
         end else if (e_win[t]) begin
            if (sq_fault[e_idx[t]]) m_v[t] = 0;
            else begin m_pc[t] = redir(e_idx[t]); m_v[t] = 1; end
         end else if (req_valid && !req_fault && req_tid == t) begin
            if (req_cmd && req_ctrl && req_ret && !req_ptaken) begin
               m_v[t] = 0; m_bs[t] = req_stage;
            end else if (!req_cmd && m_v[t]) begin
               m_pc[t] = m_pc[t] + 4; m_seq[t] = m_seq[t] + 1;
            end
         end
      end
   endtask

   task automatic cyc();
      #1;
      if (rst_n) compare(); else predict();
      @(posedge clk);
      model_step();
      @(negedge clk);
   endtask

   task automatic idle();
      req_valid = 0; req_cmd = 0; req_tid = 0; req_stage = 0; req_fault = 0;
      req_ctrl = 0; req_ret = 0; req_ptaken = 0;
      sq_vld = 0; sq_tid = 0; sq_seq = 0; sq_fault = 0; sq_ctrl = 0;
      sq_pc = 0; sq_targ = 0; sq_ds_vld = 0; sq_ds_pc = 0;
      ev_vld = 0; ev_kind = 2'd3; ev_tid = 0; ev_pc = 0;
   endtask

   task automatic ev(input int k, input int t, input logic [PC_W-1:0] pc);
      idle(); ev_vld = 1; ev_kind = 2'(k); ev_tid = TID_W'(t); ev_pc = pc; cyc();
   endtask

   task automatic rq(input bit c, input int t, input int st, input bit f,
                     input bit ct, input bit rt, input bit pt);
      req_valid = 1; req_cmd = c; req_tid = TID_W'(t); req_stage = STG_W'(st);
      req_fault = f; req_ctrl = ct; req_ret = rt; req_ptaken = pt;
   endtask

   task automatic sq(input int p, input int t, input int s, input bit f, input bit ct,
                     input logic [PC_W-1:0] pc, input logic [PC_W-1:0] tg,
                     input bit dv, input logic [PC_W-1:0] dp);
      sq_vld[p] = 1; sq_tid[p] = TID_W'(t); sq_seq[p] = SEQ_W'(s); sq_fault[p] = f;
      sq_ctrl[p] = ct; sq_pc[p] = pc; sq_targ[p] = tg; sq_ds_vld[p] = dv; sq_ds_pc[p] = dp;
   endtask

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      idle();
      @(negedge clk);
      cyc(); cyc();
      rst_n = 1;
      // R1: everything inactive after reset
      tag = "R1"; idle(); rq(0, 0, 1, 0, 0, 0, 0); cyc();
      idle(); cyc();
      // R12: activate
      tag = "R12"; ev(1, 0, 32'h1000); ev(1, 1, 32'h2000); ev(3, 2, 32'h9999);
      // R2: assigns hand out PCs and sequence numbers
      tag = "R2";
      for (int i = 0; i < 3; i++) begin idle(); rq(0, 0, 1, 0, 0, 0, 0); cyc(); end
      idle(); rq(0, 1, 1, 0, 0, 0, 0); cyc();
      // R3: inactive thread stalls
      tag = "R3"; idle(); rq(0, 2, 1, 0, 0, 0, 0); cyc(); cyc();
      // R4: faulted request
      tag = "R4"; idle(); rq(0, 0, 2, 1, 1, 1, 0); cyc(); rq(1, 0, 2, 1, 1, 0, 1); cyc();
      // R6
      tag = "R6"; idle(); rq(1, 0, 2, 0, 0, 0, 1); cyc(); rq(1, 1, 4, 0, 1, 0, 1); cyc();
      // R5: unpredicted return freezes thread 0 at stage 3
      tag = "R5"; idle(); rq(1, 0, 3, 0, 1, 1, 0); cyc();
      idle(); rq(0, 0, 1, 0, 0, 0, 0); cyc();
      // R10/R11: non-control squash unblocks stage 3
      tag = "R11"; idle(); sq(0, 0, 7, 0, 0, 32'h1100, 32'h0, 0, 0); cyc();
      tag = "R10"; idle(); rq(0, 0, 1, 0, 0, 0, 0); cyc();
      // R9: control squash, with and without delay-slot match
      tag = "R9"; idle(); sq(1, 1, 4, 0, 1, 32'h2000, 32'h3000, 1, 32'h3000); cyc();
      idle(); rq(0, 1, 0, 0, 0, 0, 0); cyc();
      idle(); sq(0, 1, 4, 0, 1, 32'h2000, 32'h5000, 1, 32'h5008); cyc();
      idle(); rq(0, 1, 0, 0, 0, 0, 0); cyc();
      // R7: older squash wins; tie goes to port 0
      tag = "R7"; idle();
      sq(0, 1, 5, 0, 1, 0, 32'h6000, 0, 0); sq(1, 1, 3, 0, 1, 0, 32'h7000, 0, 0); cyc();
      idle(); rq(0, 1, 0, 0, 0, 0, 0); cyc();
      idle(); sq(0, 1, 3, 0, 1, 0, 32'h8000, 0, 0); sq(1, 1, 3, 0, 1, 0, 32'h9000, 0, 0); cyc();
      idle(); rq(0, 1, 0, 0, 0, 0, 0); cyc();
      // R8: faulting squash then trap
      tag = "R8"; idle(); sq(0, 1, 2, 1, 0, 32'h1234, 0, 0, 0); cyc();
      idle(); rq(0, 1, 0, 0, 0, 0, 0); cyc();
      ev(0, 1, 32'hA000);
      idle(); rq(0, 1, 0, 0, 0, 0, 0); cyc();
      // R12: deactivate then squash unblocks stage 0
      tag = "R12"; idle(); rq(1, 0, 4, 0, 1, 1, 0); cyc();
      ev(2, 0, 0);
      idle(); rq(0, 0, 0, 0, 0, 0, 0); cyc();
      idle(); sq(0, 0, 1, 0, 0, 32'h4000, 0, 0, 0); cyc();
      // R13: collisions
      tag = "R13"; idle(); rq(0, 1, 0, 0, 0, 0, 0); sq(0, 1, 9, 0, 0, 32'hB000, 0, 0, 0); cyc();
      idle(); rq(0, 1, 0, 0, 0, 0, 0); cyc();
      idle(); rq(1, 2, 3, 0, 1, 1, 0); cyc();
      idle(); ev(1, 2, 32'hC000);
      idle(); rq(1, 2, 3, 0, 1, 1, 0); cyc();
      idle(); ev_vld = 1; ev_kind = 2'd0; ev_tid = 2; ev_pc = 32'hD000;
      sq(1, 2, 1, 0, 0, 32'hE000, 0, 0, 0); rq(0, 2, 0, 0, 0, 0, 0); cyc();
      idle(); rq(0, 2, 0, 0, 0, 0, 0); cyc();
      // random traffic
      tag = "R13 random";
      for (int i = 0; i < 600; i++) begin
         idle();
         if ($urandom_range(0, 9) < 7)
            rq($urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 4),
               $urandom_range(0, 9) == 0, $urandom_range(0, 1), $urandom_range(0, 1),
               $urandom_range(0, 1));
         for (int p = 0; p < NSQ; p++)
            if ($urandom_range(0, 3) == 0) begin
               logic [PC_W-1:0] tg;
               tg = 32'h100 * $urandom_range(1, 8);
               sq(p, $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 5) == 0,
                  $urandom_range(0, 1), 32'h40 * $urandom_range(0, 15), tg,
                  $urandom_range(0, 1), $urandom_range(0, 1) ? tg : tg + 8);
            end
         if ($urandom_range(0, 7) == 0) begin
            ev_vld = 1; ev_kind = 2'($urandom_range(0, 3));
            ev_tid = 2'($urandom_range(0, 3)); ev_pc = 32'h10 * $urandom_range(0, 255);
         end
         cyc();
      end
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule